// File: doc/BRIEF.md
# Thirty-Two Line Interrupt Controller

This block gathers thirty-two interrupt request lines and presents two requests to a processor: a normal one and a critical one. Software chooses, per source, whether the line is sensed by level or by edge and which polarity counts as active. Every line is first brought into the clock domain through two flip-flops. A qualifying event then sets a sticky status bit. An enable register gates these status bits, and a critical-select register steers each enabled pending bit to one of the two outputs.

Software reaches the registers through a word-addressed strobe port. A write strobe takes effect on the clock edge where it is sampled. A read strobe returns its data, together with a one-cycle valid pulse, on the following cycle. The port has no back-pressure: it accepts one access on every cycle. Each strobe is a single-cycle transfer with no ready signal, and read data is never held back. The port decodes these word offsets: status 0, enable 2, critical-select 3, polarity 4, trigger 5 and masked status 6. Source n is carried on bit 31−n of the input vector and of every register, so source 0 sits in the most significant bit.

Top module: `irq_ctrl32`

## Requirements
- R1: Source n is mapped to bit (31−n) of `irq_in` and of every register, so source 0 is bit 31.
- R2: Reads of any offset other than 0, 2, 3, 4, 5 or 6 (including 1, 7 and 8) return zero. Writes to 1, 6, 7 and 8 change no register.
- R3: A trigger bit of 1 selects edge sensing and 0 selects level sensing. A polarity bit of 1 selects a rising edge or a high level, and 0 selects a falling edge or a low level. For an edge source, the opposite transition does not set status.
- R4: Writing offset 0 clears each status bit whose write-data bit is 1 and leaves the bits written 0 unchanged. Writing all ones clears every pending edge event.
- R5: A level source that is at its active level sets its status bit on every cycle, so a clear written while the input is still active is followed by a status bit that reads as set.
- R6: Offset 6 reads status AND enable and ignores writes.
- R7: After reset, status, enable, critical-select and trigger are zero, polarity is all ones, and both outputs are low.
- R8: Status bits latch whether or not the source is enabled.
- R9: Every read strobe produces exactly one `reg_rvalid` pulse, one cycle later, carrying data sampled at the strobe edge.
- R10: `irq_norm` is the registered OR of the enabled pending bits whose critical-select bit is 0. `irq_crit` is the registered OR of those whose critical-select bit is 1.
- R11: When an active edge and a clear of the same status bit fall in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 32 | Raw request lines, source n on bit 31−n |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 4 | Word offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| irq_norm | output | 1 | Normal interrupt request |
| irq_crit | output | 1 | Critical interrupt request |

## Verification
The assertions take for granted that `irq_in` is driven with known values from reset onward. They also assume that read and write strobes are never both high in one cycle, so each assertion can compare the port against a single register access. The stimulus drives every input on the falling clock edge and issues each access as a one-cycle strobe followed by an idle cycle. Before any edge or level case is exercised, the stimulus holds each source at a steady value for at least four cycles, so that the synchroniser has settled.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned REG_AW = 4;
  typedef logic [REG_AW-1:0] reg_addr_t;

  localparam reg_addr_t ADR_STAT = 4'd0;
  localparam reg_addr_t ADR_EN   = 4'd2;
  localparam reg_addr_t ADR_CRIT = 4'd3;
  localparam reg_addr_t ADR_POL  = 4'd4;
  localparam reg_addr_t ADR_TRIG = 4'd5;
  localparam reg_addr_t ADR_MSK  = 4'd6;
endpackage

// File: rtl/irq_in_stage.sv
module irq_in_stage #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] pol,
  output logic [N-1:0] act,
  output logic [N-1:0] edge_ev
);
  logic [N-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_src
    assign act[i]     = pol[i] ? sync_q[i] : ~sync_q[i];
    assign edge_ev[i] = pol[i] ? (sync_q[i] & ~prev_q[i])
                               : (~sync_q[i] & prev_q[i]);
  end
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] trig,
  input  logic [N-1:0] act,
  input  logic [N-1:0] edge_ev,
  input  logic [N-1:0] clr,
  output logic [N-1:0] sts
);
  logic [N-1:0] set_w;

  for (genvar i = 0; i < N; i++) begin : g_set
    assign set_w[i] = trig[i] ? edge_ev[i] : act[i];
  end

  // new events take precedence over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) sts <= '0;
    else        sts <= (sts & ~clr) | set_w;
  end
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] sts,
  input  logic [N-1:0] en,
  input  logic [N-1:0] crit,
  output logic [N-1:0] msk,
  output logic         irq_norm,
  output logic         irq_crit
);
  assign msk = sts & en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_norm <= 1'b0;
      irq_crit <= 1'b0;
    end else begin
      irq_norm <= |(msk & ~crit);
      irq_crit <= |(msk & crit);
    end
  end
endmodule

// File: rtl/irq_ctrl32.sv
module irq_ctrl32
  import irq_ctrl_pkg::*;
#(
  parameter int N = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      irq_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [N-1:0]      reg_wdata,
  output logic [N-1:0]      reg_rdata,
  output logic              reg_rvalid,
  output logic              irq_norm,
  output logic              irq_crit
);
  logic [N-1:0] en_q, crit_q, pol_q, trig_q;
  logic [N-1:0] act_w, edge_w, sts_q, msk_w, clr_w;

  assign clr_w = (reg_wr && reg_addr == ADR_STAT) ? reg_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      crit_q <= '0;
      pol_q  <= '1;
      trig_q <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        ADR_EN:   en_q   <= reg_wdata;
        ADR_CRIT: crit_q <= reg_wdata;
        ADR_POL:  pol_q  <= reg_wdata;
        ADR_TRIG: trig_q <= reg_wdata;
        default:  ;
      endcase
    end
  end

  irq_in_stage #(.N(N)) u_in (
    .clk(clk), .rst_n(rst_n), .raw(irq_in), .pol(pol_q),
    .act(act_w), .edge_ev(edge_w)
  );

  irq_status_bank #(.N(N)) u_sts (
    .clk(clk), .rst_n(rst_n), .trig(trig_q), .act(act_w),
    .edge_ev(edge_w), .clr(clr_w), .sts(sts_q)
  );

  irq_out_stage #(.N(N)) u_out (
    .clk(clk), .rst_n(rst_n), .sts(sts_q), .en(en_q), .crit(crit_q),
    .msk(msk_w), .irq_norm(irq_norm), .irq_crit(irq_crit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) begin
        case (reg_addr)
          ADR_STAT: reg_rdata <= sts_q;
          ADR_EN:   reg_rdata <= en_q;
          ADR_CRIT: reg_rdata <= crit_q;
          ADR_POL:  reg_rdata <= pol_q;
          ADR_TRIG: reg_rdata <= trig_q;
          ADR_MSK:  reg_rdata <= msk_w;
          default:  reg_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_ctrl32_chk.sv
module irq_ctrl32_chk
  import irq_ctrl_pkg::*;
#(
  parameter int N = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_rd,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [N-1:0]      reg_wdata,
  input logic [N-1:0]      reg_rdata,
  input logic              reg_rvalid,
  input logic              irq_norm,
  input logic              irq_crit,
  input logic [N-1:0]      sts,
  input logic [N-1:0]      en,
  input logic [N-1:0]      crit,
  input logic [N-1:0]      trig,
  input logic [N-1:0]      act,
  input logic [N-1:0]      edge_ev
);
  logic unmapped;
  assign unmapped = !(reg_addr inside {ADR_STAT, ADR_EN, ADR_CRIT, ADR_POL, ADR_TRIG, ADR_MSK});

  assert_rvalid_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  assert_no_spurious_rvalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);

  assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && unmapped) |=> reg_rdata == '0);

  assert_masked_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADR_MSK) |=> reg_rdata == ($past(sts) & $past(en)));

  assert_level_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(act & ~trig) & ~sts) == '0));

  assert_edge_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADR_STAT && |(edge_ev & trig & reg_wdata))
      |=> ((sts & $past(edge_ev & trig & reg_wdata)) == $past(edge_ev & trig & reg_wdata)));

  assert_crit_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_crit == $past(|(sts & en & crit)));

  assert_norm_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_norm == $past(|(sts & en & ~crit)));

  assert_reset_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en == '0 && crit == '0 && trig == '0 && sts == '0));
endmodule

bind irq_ctrl32 irq_ctrl32_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .reg_rvalid(reg_rvalid), .irq_norm(irq_norm), .irq_crit(irq_crit),
  .sts(sts_q), .en(en_q), .crit(crit_q), .trig(trig_q),
  .act(act_w), .edge_ev(edge_w)
);

// File: tb/irq_ctrl32_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl32_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] irq_in = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid, irq_norm, irq_crit;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  irq_ctrl32 dut_i (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .irq_norm(irq_norm), .irq_crit(irq_crit)
  );

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // driver: pushes the expected word, then issues the strobe
  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // monitor: pops and compares on each returned read
  always @(negedge clk) begin
    if (rst_n && reg_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R9 unexpected rvalid actual=%h expected=none", reg_rdata);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (reg_rdata !== e) begin
          failures++;
          $display("FAIL %s actual=%h expected=%h", t, reg_rdata, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    // R7 reset state
    chk(irq_norm, 1'b0, "R7 irq_norm");
    chk(irq_crit, 1'b0, "R7 irq_crit");
    rd(4'd0, 32'h0, "R7 status");
    rd(4'd2, 32'h0, "R7 enable");
    rd(4'd3, 32'h0, "R7 crit");
    rd(4'd4, 32'hFFFF_FFFF, "R7 polarity");
    rd(4'd5, 32'h0, "R7 trigger");
    rd(4'd6, 32'h0, "R7 masked");
    // R2 unmapped offsets
    rd(4'd1, 32'h0, "R2 offset1");
    rd(4'd7, 32'h0, "R2 offset7");
    rd(4'd8, 32'h0, "R2 offset8");

    // R1 R5 R8: source 0 (bit 31) level high, disabled
    @(negedge clk); irq_in[31] = 1'b1;
    idle(4);
    rd(4'd0, 32'h8000_0000, "R1 R8 source0 latched while disabled");
    rd(4'd6, 32'h0, "R6 masked with enable off");
    wr(4'd0, 32'h8000_0000);
    rd(4'd0, 32'h8000_0000, "R5 clear while level active");
    @(negedge clk); irq_in[31] = 1'b0;
    idle(4);
    wr(4'd0, 32'h8000_0000);
    rd(4'd0, 32'h0, "R4 clear after level drops");

    // R3 active-low level on bit 27
    wr(4'd4, 32'hF7FF_FFFF);
    idle(3);
    rd(4'd0, 32'h0800_0000, "R3 active-low level");
    @(negedge clk); irq_in[27] = 1'b1;
    idle(4);
    wr(4'd0, 32'h0800_0000);
    rd(4'd0, 32'h0, "R4 clear inactive low source");

    // R3 rising edge on bit 30
    wr(4'd5, 32'h4000_0000);
    @(negedge clk); irq_in[30] = 1'b1;
    idle(4);
    rd(4'd0, 32'h4000_0000, "R3 rising edge");
    wr(4'd0, 32'h4000_0000);
    rd(4'd0, 32'h0, "R4 edge clear holds while input high");
    @(negedge clk); irq_in[30] = 1'b0;
    idle(4);
    rd(4'd0, 32'h0, "R3 falling ignored on rising source");

    // R3 falling edge on bit 29
    wr(4'd5, 32'h6000_0000);
    wr(4'd4, 32'hD7FF_FFFF);
    @(negedge clk); irq_in[29] = 1'b1;
    idle(4);
    rd(4'd0, 32'h0, "R3 rise ignored on falling source");
    @(negedge clk); irq_in[29] = 1'b0;
    idle(4);
    rd(4'd0, 32'h2000_0000, "R3 falling edge");

    // R10 outputs
    wr(4'd2, 32'h2000_0000);
    idle(2);
    chk(irq_norm, 1'b1, "R10 normal asserted");
    chk(irq_crit, 1'b0, "R10 critical idle");
    rd(4'd6, 32'h2000_0000, "R6 masked status");
    wr(4'd3, 32'h2000_0000);
    idle(2);
    chk(irq_norm, 1'b0, "R10 normal released");
    chk(irq_crit, 1'b1, "R10 critical asserted");
    wr(4'd2, 32'h0);
    idle(2);
    chk(irq_crit, 1'b0, "R10 critical off when disabled");
    rd(4'd0, 32'h2000_0000, "R8 status kept while disabled");
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, 32'h0, "R4 all ones clears");

    // R11 edge and clear in same cycle on bit 28
    wr(4'd5, 32'h7000_0000);
    @(negedge clk); irq_in[28] = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 32'h1000_0000;
    @(negedge clk); reg_wr = 1'b0;
    rd(4'd0, 32'h1000_0000, "R11 event beats clear");
    wr(4'd0, 32'h1000_0000);
    rd(4'd0, 32'h0, "R4 later clear");

    // R6 R2 writes to read-only / unmapped offsets
    wr(4'd2, 32'hFFFF_FFFF);
    @(negedge clk); irq_in[31] = 1'b1;
    idle(4);
    wr(4'd6, 32'h0);
    rd(4'd6, 32'h8000_0000, "R6 write to masked ignored");
    wr(4'd7, 32'h0);
    wr(4'd1, 32'h0);
    rd(4'd2, 32'hFFFF_FFFF, "R2 enable untouched by offset 1/7 writes");
    rd(4'd5, 32'h7000_0000, "R2 trigger untouched");
    chk(irq_norm, 1'b1, "R10 normal from source0");

    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      failures++;
      $display("FAIL R9 missing read data actual=%0d expected=0", exp_q.size());
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule